// File: doc/BRIEF.md
# Two-Line LRU Read Buffer

This block sits in front of a local SRAM and serves two read requesters: a CPU operand port and an FPU read port. Both requesters share one small store of two fully associative entries. Each entry holds one 32-byte line. When a read finds its line in the store, the word comes back in the same cycle as the request. When it does not, the block asks the SRAM for the whole aligned 32-byte line. It returns the requested word in the cycle the line arrives, and it writes the line into the entry that was used least recently.

Writes do not pass through the store. The CPU write path and an external bus-master write path both go straight to the SRAM. This block only watches their addresses and drops any buffered copy of the written line, so software never has to manage coherency. A requester raises its request, holds the address steady and waits for its ready. The CPU port wins when both ports ask at once.

Top module: `rdbuf_lru2`

## Requirements
- R1: After reset both entries are empty, no ready and no line fetch are asserted, and the first refill goes to entry 0.
- R2: A read whose line is held in a valid entry raises that port's ready in the request cycle. Its data is the word selected by address bits [4:2], where word 0 is bits [31:0] of the line.
- R3: On a miss, ready stays low in the request cycle. From the next cycle the line fetch request is held, with the address's low 5 bits forced to zero. Ready and the word are given in the cycle the line arrives.
- R4: After a refill, later reads anywhere in that line hit, as long as no invalidating write touches it.
- R5: A refill replaces the entry that was not used most recently. Both hits and refills count as uses.
- R6: When both ports request together while no refill is running, the CPU port is served first and the FPU port's ready stays low. The FPU port is served afterwards.
- R7: While a refill is pending, the port that did not cause it gets no ready. The two readies are never high together.
- R8: A CPU write into a buffered line invalidates that entry, so the next read of that line misses. A write to a line that is not buffered changes nothing.
- R9: A bus-master write invalidates a matching buffered line in the same way as a CPU write.
- R10: A write during a refill to the line being fetched lets the requester receive the fetched word, but the entry is left invalid, so the next read of that line misses.
- R11: A line brought in by one port hits for the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd_req | input | 1 | CPU operand read request, held until ready |
| cpu_rd_addr | input | 16 | CPU byte address |
| cpu_rd_ready | output | 1 | CPU read completes this cycle |
| cpu_rd_data | output | 32 | CPU read word |
| fpu_rd_req | input | 1 | FPU read request, held until ready |
| fpu_rd_addr | input | 16 | FPU byte address |
| fpu_rd_ready | output | 1 | FPU read completes this cycle |
| fpu_rd_data | output | 32 | FPU read word |
| cpu_wr_en | input | 1 | CPU write to the SRAM this cycle |
| cpu_wr_addr | input | 16 | CPU write byte address |
| bm_wr_en | input | 1 | Bus-master write to the SRAM this cycle |
| bm_wr_addr | input | 16 | Bus-master write byte address |
| mem_rd_req | output | 1 | Line fetch request to the SRAM |
| mem_rd_addr | output | 16 | Line-aligned fetch address |
| mem_rd_valid | input | 1 | Fetched line is present this cycle |
| mem_rd_line | input | 256 | Fetched line, word 0 in the low bits |

## Verification
A valid bit that stays set after a write shows up at the very next read of that line. The read completes with zero wait cycles and returns the old line version where a fetch was due. A wrong LRU bit is harder to spot: it appears only on the next miss, when the wrong entry is evicted, and the evicted line then misses at its next read. So the bench keeps an independent model of the tags, the valid bits and the LRU bit. Every read checks both its latency and its data against that model, so either fault is reported at the first access that depends on it.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;

    localparam int ADDR_W     = 16;
    localparam int WORD_W     = 32;
    localparam int LINE_BYTES = 32;
    localparam int NUM_ENT    = 2;

    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WB_W       = $clog2(WORD_BYTES);
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int TAG_W      = ADDR_W - OFF_W;
    localparam int LINE_W     = LINE_BYTES * 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic {ST_IDLE, ST_FILL} fill_st_e;
    typedef enum logic {OWN_CPU, OWN_FPU} owner_e;

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic addr_t line_base(addr_t a);
        return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

    function automatic word_t pick_word(line_t l, addr_t a);
        int idx;
        idx = int'(a[OFF_W-1:WB_W]);
        return l[idx*WORD_W +: WORD_W];
    endfunction

endpackage

// File: rtl/rdbuf_entry.sv
module rdbuf_entry
    import rdbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tag_t  look_tag,
    output logic  hit,
    output line_t line_out,
    input  logic  fill_en,
    input  tag_t  fill_tag,
    input  line_t fill_line,
    input  logic  fill_keep,
    input  logic  inv_a_en,
    input  addr_t inv_a_addr,
    input  logic  inv_b_en,
    input  addr_t inv_b_addr
);

    logic  valid_q;
    tag_t  tag_q;
    line_t line_q;
    logic  inv_hit;

    assign hit      = valid_q && (tag_q == look_tag);
    assign line_out = line_q;
    assign inv_hit  = valid_q &&
                      ((inv_a_en && (tag_of(inv_a_addr) == tag_q)) ||
                       (inv_b_en && (tag_of(inv_b_addr) == tag_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            line_q  <= '0;
        end else if (fill_en) begin
            valid_q <= fill_keep;
            tag_q   <= fill_tag;
            line_q  <= fill_line;
        end else if (inv_hit) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rdbuf_lru.sv
module rdbuf_lru (
    input  logic clk,
    input  logic rst,
    input  logic touch_en,
    input  logic touch_idx,
    output logic victim
);

    always_ff @(posedge clk) begin
        if (rst) begin
            victim <= 1'b0;
        end else if (touch_en) begin
            victim <= ~touch_idx;
        end
    end

endmodule

// File: rtl/rdbuf_arb.sv
module rdbuf_arb (
    input  logic cpu_req,
    input  logic fpu_req,
    output logic gnt_cpu,
    output logic any_req
);

    assign gnt_cpu = cpu_req;
    assign any_req = cpu_req || fpu_req;

endmodule

// File: rtl/rdbuf_lru2.sv
module rdbuf_lru2
    import rdbuf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_rd_req,
    input  logic [ADDR_W-1:0]     cpu_rd_addr,
    output logic                  cpu_rd_ready,
    output logic [WORD_W-1:0]     cpu_rd_data,
    input  logic                  fpu_rd_req,
    input  logic [ADDR_W-1:0]     fpu_rd_addr,
    output logic                  fpu_rd_ready,
    output logic [WORD_W-1:0]     fpu_rd_data,
    input  logic                  cpu_wr_en,
    input  logic [ADDR_W-1:0]     cpu_wr_addr,
    input  logic                  bm_wr_en,
    input  logic [ADDR_W-1:0]     bm_wr_addr,
    output logic                  mem_rd_req,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic                  mem_rd_valid,
    input  logic [LINE_W-1:0]     mem_rd_line
);

    fill_st_e state_q;
    owner_e   owner_q;
    addr_t    fill_addr_q;
    logic     poison_q;

    logic  gnt_cpu, any_req;
    addr_t sel_addr;
    tag_t  look_tag;
    logic [NUM_ENT-1:0] hit_vec;
    line_t ent_line [NUM_ENT];
    logic  victim;
    logic  hit_any, hit_idx;
    logic  idle_hit, idle_miss;
    logic  fill_done, poison_now, fill_keep;
    logic  touch_en, touch_idx;
    logic  resp_valid, resp_cpu;
    word_t resp_word;

    rdbuf_arb u_arb (
        .cpu_req (cpu_rd_req),
        .fpu_req (fpu_rd_req),
        .gnt_cpu (gnt_cpu),
        .any_req (any_req)
    );

    assign sel_addr = gnt_cpu ? cpu_rd_addr : fpu_rd_addr;
    assign look_tag = tag_of(sel_addr);

    assign fill_done  = (state_q == ST_FILL) && mem_rd_valid;
    assign poison_now = (state_q == ST_FILL) &&
                        ((cpu_wr_en && (tag_of(cpu_wr_addr) == tag_of(fill_addr_q))) ||
                         (bm_wr_en  && (tag_of(bm_wr_addr)  == tag_of(fill_addr_q))));
    assign fill_keep  = !(poison_q || poison_now);

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        rdbuf_entry u_entry (
            .clk        (clk),
            .rst        (rst),
            .look_tag   (look_tag),
            .hit        (hit_vec[e]),
            .line_out   (ent_line[e]),
            .fill_en    (fill_done && (victim == 1'(e))),
            .fill_tag   (tag_of(fill_addr_q)),
            .fill_line  (mem_rd_line),
            .fill_keep  (fill_keep),
            .inv_a_en   (cpu_wr_en),
            .inv_a_addr (cpu_wr_addr),
            .inv_b_en   (bm_wr_en),
            .inv_b_addr (bm_wr_addr)
        );
    end

    assign hit_any   = |hit_vec;
    assign hit_idx   = hit_vec[1];
    assign idle_hit  = (state_q == ST_IDLE) && any_req && hit_any;
    assign idle_miss = (state_q == ST_IDLE) && any_req && !hit_any;

    assign touch_en  = idle_hit || fill_done;
    assign touch_idx = fill_done ? victim : hit_idx;

    rdbuf_lru u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    always_comb begin
        resp_valid = 1'b0;
        resp_cpu   = 1'b0;
        resp_word  = '0;
        if (idle_hit) begin
            resp_valid = 1'b1;
            resp_cpu   = gnt_cpu;
            resp_word  = pick_word(ent_line[hit_idx], sel_addr);
        end else if (fill_done) begin
            resp_valid = 1'b1;
            resp_cpu   = (owner_q == OWN_CPU);
            resp_word  = pick_word(mem_rd_line, fill_addr_q);
        end
    end

    assign cpu_rd_ready = resp_valid && resp_cpu;
    assign fpu_rd_ready = resp_valid && !resp_cpu;
    assign cpu_rd_data  = resp_word;
    assign fpu_rd_data  = resp_word;

    assign mem_rd_req  = (state_q == ST_FILL);
    assign mem_rd_addr = line_base(fill_addr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            owner_q     <= OWN_CPU;
            fill_addr_q <= '0;
            poison_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (idle_miss) begin
                        state_q     <= ST_FILL;
                        owner_q     <= gnt_cpu ? OWN_CPU : OWN_FPU;
                        fill_addr_q <= sel_addr;
                        poison_q    <= 1'b0;
                    end
                end
                ST_FILL: begin
                    if (mem_rd_valid) begin
                        state_q  <= ST_IDLE;
                        poison_q <= 1'b0;
                    end else begin
                        poison_q <= poison_q || poison_now;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rdbuf_lru2_chk.sv
module rdbuf_lru2_chk
    import rdbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_rd_req,
    input logic              cpu_rd_ready,
    input logic              fpu_rd_req,
    input logic              fpu_rd_ready,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid
);

    a_r3_fetch_held: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

    a_r3_fetch_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0));

    a_r3_fill_answers: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req && mem_rd_valid |-> (cpu_rd_ready || fpu_rd_ready));

    a_r2_cpu_ready_needs_req: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_ready |-> cpu_rd_req);

    a_r2_fpu_ready_needs_req: assert property (@(posedge clk) disable iff (rst)
        fpu_rd_ready |-> fpu_rd_req);

    a_r6_cpu_first: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_req && fpu_rd_req && !mem_rd_req |-> !fpu_rd_ready);

    a_r7_one_ready: assert property (@(posedge clk) disable iff (rst)
        $countones({cpu_rd_ready, fpu_rd_ready}) <= 1);

    a_r7_wait_while_pending: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req && !mem_rd_valid |-> !cpu_rd_ready && !fpu_rd_ready);

endmodule

bind rdbuf_lru2 rdbuf_lru2_chk i_chk (.*);

// File: tb/test_rdbuf_lru2.sv
module test_rdbuf_lru2;
    import rdbuf_pkg::*;

    localparam int LAT = 3;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  cpu_rd_req = 1'b0, fpu_rd_req = 1'b0;
    addr_t cpu_rd_addr = '0, fpu_rd_addr = '0;
    logic  cpu_rd_ready, fpu_rd_ready;
    word_t cpu_rd_data, fpu_rd_data;
    logic  cpu_wr_en = 1'b0, bm_wr_en = 1'b0;
    addr_t cpu_wr_addr = '0, bm_wr_addr = '0;
    logic  mem_rd_req;
    addr_t mem_rd_addr;
    logic  mem_rd_valid = 1'b0;
    line_t mem_rd_line = '0;

    int n_tests = 0;
    int n_fail  = 0;

    int   lver [1 << TAG_W];
    logic m_valid [NUM_ENT];
    tag_t m_tag [NUM_ENT];
    logic m_lru;

    always #5 clk = ~clk;

    rdbuf_lru2 i_rdbuf_lru2 (.*);

    function automatic word_t mk_word(addr_t a);
        tag_t t;
        logic [7:0] v;
        t = tag_of(a);
        v = 8'(lver[t]);
        return {v, 5'b0, t, 5'b0, a[OFF_W-1:WB_W]};
    endfunction

    function automatic line_t mk_line(addr_t la);
        line_t l;
        l = '0;
        for (int w = 0; w < WORDS; w++) begin
            l[w*WORD_W +: WORD_W] = mk_word({la[ADDR_W-1:OFF_W], WSEL_W'(w), {WB_W{1'b0}}});
        end
        return l;
    endfunction

    function automatic addr_t mk_addr(int t, int w);
        return {TAG_W'(t), WSEL_W'(w), {WB_W{1'b0}}};
    endfunction

    task automatic check(input logic ok, input string what, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic model_read(input addr_t a, input logic keep, output logic exp_hit);
        tag_t t;
        int   idx;
        t = tag_of(a);
        exp_hit = 1'b0;
        idx = 0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (m_valid[i] && m_tag[i] == t) begin
                exp_hit = 1'b1;
                idx = i;
            end
        end
        if (exp_hit) begin
            m_lru = ~1'(idx);
        end else begin
            m_tag[m_lru]   = t;
            m_valid[m_lru] = keep;
            m_lru          = ~m_lru;
        end
    endtask

    task automatic model_write(input addr_t a);
        tag_t t;
        t = tag_of(a);
        lver[t]++;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (m_tag[i] == t) m_valid[i] = 1'b0;
        end
    endtask

    // Memory model: answers a held line fetch LAT cycles after it is first seen.
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rd_req && !mem_rd_valid) begin
                cnt++;
                if (cnt == LAT) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_line  = mk_line(mem_rd_addr);
                    cnt = 0;
                end
            end else begin
                mem_rd_valid = 1'b0;
            end
        end
    end

    // Polls the port until ready; the other port must stay idle meanwhile (R7).
    task automatic wait_ready(input bit fpu, input addr_t a, output int cyc, output word_t d);
        logic rdy, other;
        cyc = 0;
        #1;
        rdy   = fpu ? fpu_rd_ready : cpu_rd_ready;
        other = fpu ? cpu_rd_ready : fpu_rd_ready;
        while (!rdy && cyc < 50) begin
            check(!other, "R7 other port ready during wait", other, 0);
            @(negedge clk);
            #1;
            cyc++;
            if (cyc == 1) begin
                check(mem_rd_req && mem_rd_addr == line_base(a),
                      "R3 fetch request and aligned address", mem_rd_addr, line_base(a));
            end
            rdy   = fpu ? fpu_rd_ready : cpu_rd_ready;
            other = fpu ? cpu_rd_ready : fpu_rd_ready;
        end
        d = fpu ? fpu_rd_data : cpu_rd_data;
    endtask

    task automatic do_read(input bit fpu, input addr_t a, input string rq);
        logic  eh;
        int    cyc;
        word_t d, ew;
        model_read(a, 1'b1, eh);
        ew = mk_word(a);
        if (fpu) begin fpu_rd_req = 1'b1; fpu_rd_addr = a; end
        else     begin cpu_rd_req = 1'b1; cpu_rd_addr = a; end
        wait_ready(fpu, a, cyc, d);
        check(cyc == (eh ? 0 : LAT), {rq, " latency (0 hit R2, LAT miss R3)"}, cyc, eh ? 0 : LAT);
        check(d == ew, {rq, " data"}, d, ew);
        @(negedge clk);
        cpu_rd_req = 1'b0;
        fpu_rd_req = 1'b0;
    endtask

    task automatic do_write(input bit bm, input addr_t a);
        if (bm) begin bm_wr_en = 1'b1; bm_wr_addr = a; end
        else    begin cpu_wr_en = 1'b1; cpu_wr_addr = a; end
        model_write(a);
        @(negedge clk);
        cpu_wr_en = 1'b0;
        bm_wr_en  = 1'b0;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic  eh;
        int    cyc;
        word_t d;
        logic [15:0] lf;

        for (int i = 0; i < (1 << TAG_W); i++) lver[i] = i * 7;
        for (int i = 0; i < NUM_ENT; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end
        m_lru = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: nothing active after reset
        check(!cpu_rd_ready && !fpu_rd_ready && !mem_rd_req, "R1 idle after reset",
              {cpu_rd_ready, fpu_rd_ready, mem_rd_req}, 0);
        @(negedge clk);

        // R1/R3/R5: first miss fills entry 0, then LRU order decides evictions
        do_read(1'b0, mk_addr(2, 3), "R1 first read misses");
        do_read(1'b0, mk_addr(4, 0), "R3 second line miss");
        do_read(1'b0, mk_addr(2, 5), "R4 refilled line hits");
        do_read(1'b0, mk_addr(6, 7), "R5 evicts least recent");
        do_read(1'b0, mk_addr(2, 0), "R5 recent line kept");
        do_read(1'b0, mk_addr(4, 1), "R5 evicted line misses");

        // R11: FPU hits a line brought in by the CPU
        do_read(1'b1, mk_addr(4, 6), "R11 fpu shares cpu line");

        // R8: CPU write invalidates; write elsewhere has no effect
        do_write(1'b0, mk_addr(2, 1));
        do_write(1'b0, mk_addr(9, 1));
        do_read(1'b0, mk_addr(4, 2), "R8 unrelated write keeps line");
        do_read(1'b0, mk_addr(2, 1), "R8 written line misses");

        // R9: bus-master write invalidates
        do_write(1'b1, mk_addr(4, 4));
        do_read(1'b1, mk_addr(4, 4), "R9 bus-master write invalidates");

        // R6: simultaneous hits, CPU first
        do_read(1'b0, mk_addr(12, 0), "R6 prefill");
        model_read(mk_addr(12, 1), 1'b1, eh);
        model_read(mk_addr(12, 2), 1'b1, eh);
        cpu_rd_req = 1'b1; cpu_rd_addr = mk_addr(12, 1);
        fpu_rd_req = 1'b1; fpu_rd_addr = mk_addr(12, 2);
        #1;
        check(cpu_rd_ready && !fpu_rd_ready, "R6 cpu served first",
              {cpu_rd_ready, fpu_rd_ready}, 2'b10);
        check(cpu_rd_data == mk_word(mk_addr(12, 1)), "R6 cpu data", cpu_rd_data, mk_word(mk_addr(12, 1)));
        @(negedge clk);
        cpu_rd_req = 1'b0;
        #1;
        check(fpu_rd_ready, "R6 fpu served next", fpu_rd_ready, 1);
        check(fpu_rd_data == mk_word(mk_addr(12, 2)), "R6 fpu data", fpu_rd_data, mk_word(mk_addr(12, 2)));
        @(negedge clk);
        fpu_rd_req = 1'b0;

        // R7: simultaneous misses, FPU waits through the CPU refill
        model_read(mk_addr(20, 3), 1'b1, eh);
        cpu_rd_req = 1'b1; cpu_rd_addr = mk_addr(20, 3);
        fpu_rd_req = 1'b1; fpu_rd_addr = mk_addr(21, 5);
        wait_ready(1'b0, mk_addr(20, 3), cyc, d);
        check(cyc == LAT, "R7 cpu refill latency", cyc, LAT);
        check(!fpu_rd_ready, "R7 fpu held at cpu completion", fpu_rd_ready, 0);
        check(d == mk_word(mk_addr(20, 3)), "R7 cpu data", d, mk_word(mk_addr(20, 3)));
        @(negedge clk);
        cpu_rd_req = 1'b0;
        model_read(mk_addr(21, 5), 1'b1, eh);
        wait_ready(1'b1, mk_addr(21, 5), cyc, d);
        check(cyc == LAT, "R7 fpu own refill latency", cyc, LAT);
        check(d == mk_word(mk_addr(21, 5)), "R7 fpu data", d, mk_word(mk_addr(21, 5)));
        @(negedge clk);
        fpu_rd_req = 1'b0;

        // R10: write to the line under refill
        cpu_rd_req = 1'b1; cpu_rd_addr = mk_addr(30, 2);
        #1;
        check(!cpu_rd_ready, "R10 miss not ready", cpu_rd_ready, 0);
        @(negedge clk);
        bm_wr_en = 1'b1; bm_wr_addr = mk_addr(30, 6);
        model_write(mk_addr(30, 6));
        @(negedge clk);
        bm_wr_en = 1'b0;
        model_read(mk_addr(30, 2), 1'b0, eh);
        wait_ready(1'b0, mk_addr(30, 2), cyc, d);
        check(d == mk_word(mk_addr(30, 2)), "R10 requester gets fetched word", d, mk_word(mk_addr(30, 2)));
        @(negedge clk);
        cpu_rd_req = 1'b0;
        do_read(1'b0, mk_addr(30, 2), "R10 poisoned line misses again");

        // Sweep: four lines, both ports, writes from both sources
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            addr_t a;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a = mk_addr(int'(lf[4:3]), int'(lf[7:5]));
            case (lf[1:0])
                2'd0, 2'd1: do_read(1'b0, a, "R4 sweep cpu");
                2'd2:       do_read(1'b1, a, "R5 sweep fpu");
                default:    do_write(lf[8], a);
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule